// File: doc/BRIEF.md
# FFT RAM address generator

This block sequences the RAM addresses of an in-place 1024-point radix-2 FFT. The data lives in two RAM banks of 512 words each. A sample index is split into a 9-bit word address and a bank bit. The bank bit is the parity of the 10-bit index, so two indices that differ in a single bit always land in different banks.

The block has three working modes and one idle mode. In the load mode it walks the index 0..1023 in natural order. In the unload mode it walks the same index but emits the bit-reversed value. In the transform mode an 8-bit step counter `m` is widened to a 10-bit base index `k1`. This is done by inserting two zero bits at the stage-dependent positions of the weights `Ns` and `BF`. Four addresses are then formed from `k1`: one with no offset, one with `Ns` added, one with `BF` added and one with both added. The stage advances after every 256 steps, running 1..10 and then wrapping back to 1.

All results are registered and appear one clock after the step strobe that requested them. Any change of mode restarts the counters.

Top module: `fft_addr_gen`

## Requirements
- R1: While reset is held and just after it, valid_o is 0, stage_o is 1 and all address outputs and bank_o are 0.
- R2: valid_o is 1 in the cycle after a clock edge where step_i is 1 and mode_i is not idle (3); otherwise it is 0. In idle mode nothing advances.
- R3: In load mode (mode_i = 0), step n after entering the mode (counted from 0) gives a00_o = n[8:0] and bank_o = XOR of the bits of n mod 1024. The index wraps from 1023 to 0.
- R4: In unload mode (mode_i = 2), step n gives r = n mod 1024 bit-reversed over 10 bits, a00_o = r[8:0] and bank_o = XOR of the bits of r.
- R5: A change of mode_i from its value in the previous cycle restarts the index at 0 and the stage at 1, including on the step taken in that same cycle.
- R6: In transform mode (mode_i = 1), the base index k1 is the 8-bit step count m with zero bits inserted at bit positions p and p+1. Here p = 8 for stages 1 and 2, and p = 10 − stage otherwise. Bits of m below p keep their place and the remaining bits move up by two.
- R7: In transform mode, Ns = 1024 >> stage, BF = Ns/2 in stage 1 and 2·Ns in later stages. The outputs are a00_o = k1, a01_o = k1+Ns, a11_o = k1+BF and a10_o = k1+Ns+BF, each truncated to 9 bits.
- R8: In transform mode, bank_o = XOR of the bits of k1. It names the bank of a00_o and a10_o, while a01_o and a11_o lie in the other bank.
- R9: stage_o reports the stage used for the presented addresses. The stage rises by one after the step with m = 255, and stage 10 is followed by stage 1. It always lies in 1..10.
- R10: In load and unload modes a01_o, a10_o and a11_o are 0.
- R11: Without an accepted step (step_i = 0 or idle mode), the address outputs, bank_o and stage_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 load, 1 transform, 2 unload, 3 idle |
| step_i | input | 1 | Advance one step |
| a00_o | output | 9 | Generator 0, first address |
| a10_o | output | 9 | Generator 0, second address |
| a01_o | output | 9 | Generator 1, first address |
| a11_o | output | 9 | Generator 1, second address |
| bank_o | output | 1 | Bank of a00_o (and a10_o in transform mode) |
| stage_o | output | 4 | Stage of the presented addresses |
| valid_o | output | 1 | Addresses updated by the last step |

## Verification
A step counter that is off by one appears on a00_o at the very next valid output. A stage register that advances too early or too late only shows after 256 transform steps, once the inserted bit positions fail to move. Both checks therefore run complete ten-stage passes, as well as random mode changes. A wrong bit-insertion position breaks the relation between the four addresses within the same cycle: a10_o must equal the OR of a01_o and a11_o. A wrong bank choice only becomes visible as parity against the expected index.

// File: rtl/fft_ag_pkg.sv
package fft_ag_pkg;
  localparam int unsigned LOG_N = 10;
  localparam int unsigned AW    = LOG_N - 1;
  localparam int unsigned MW    = LOG_N - 2;
  localparam int unsigned SW    = 4;

  typedef enum logic [1:0] {
    MODE_IN   = 2'd0,
    MODE_FFT  = 2'd1,
    MODE_OUT  = 2'd2,
    MODE_IDLE = 2'd3
  } mode_e;
endpackage

// File: rtl/fft_ag_seq.sv
module fft_ag_seq
  import fft_ag_pkg::*;
#(
  parameter int unsigned LW = LOG_N,
  parameter int unsigned SB = SW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          step_i,
  output logic          act_o,
  output logic [LW-1:0] cnt_o,
  output logic [SB-1:0] stage_o
);
  localparam int unsigned MB = LW - 2;
  localparam logic [SB-1:0] LAST_STAGE = SB'(LW);

  logic [1:0]    mode_q;
  logic [LW-1:0] cnt_q;
  logic [SB-1:0] stage_q;
  logic          restart;
  logic          wrap;

  assign restart = mode_i != mode_q;
  assign cnt_o   = restart ? '0 : cnt_q;
  assign stage_o = restart ? SB'(1) : stage_q;
  assign act_o   = step_i && (mode_i != MODE_IDLE);
  assign wrap    = act_o && (mode_i == MODE_FFT) && (&cnt_o[MB-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_IN;
      cnt_q   <= '0;
      stage_q <= SB'(1);
    end else begin
      mode_q  <= mode_i;
      cnt_q   <= act_o ? cnt_o + LW'(1) : cnt_o;
      if (wrap) stage_q <= (stage_o == LAST_STAGE) ? SB'(1) : stage_o + SB'(1);
      else      stage_q <= stage_o;
    end
  end
endmodule

// File: rtl/fft_ag_io.sv
module fft_ag_io
  import fft_ag_pkg::*;
#(
  parameter int unsigned LW = LOG_N
) (
  input  logic          rev_i,
  input  logic [LW-1:0] idx_i,
  output logic [LW-2:0] addr_o,
  output logic          bank_o
);
  logic [LW-1:0] sel;

  for (genvar g = 0; g < LW; g++) begin : g_rev
    assign sel[g] = rev_i ? idx_i[LW-1-g] : idx_i[g];
  end

  assign addr_o = sel[LW-2:0];
  assign bank_o = ^sel;
endmodule

// File: rtl/fft_ag_bfly.sv
module fft_ag_bfly
  import fft_ag_pkg::*;
#(
  parameter int unsigned LW = LOG_N,
  parameter int unsigned SB = SW
) (
  input  logic [LW-3:0] m_i,
  input  logic [SB-1:0] stage_i,
  output logic [LW-2:0] a00_o,
  output logic [LW-2:0] a10_o,
  output logic [LW-2:0] a01_o,
  output logic [LW-2:0] a11_o,
  output logic          bank_o
);
  localparam int unsigned MB = LW - 2;

  int unsigned   pos;
  logic [LW-1:0] k1, ns_w, bf_w;

  always_comb begin
    pos = (int'(stage_i) <= 2) ? LW - 2 : LW - int'(stage_i);
    k1  = '0;
    for (int j = 0; j < LW; j++) begin
      if (j < int'(pos))            k1[j] = m_i[j];
      else if (j >= int'(pos) + 2)  k1[j] = m_i[j-2];
    end
    ns_w = LW'(1) << (LW - int'(stage_i));
    bf_w = (stage_i == SB'(1)) ? (ns_w >> 1) : (ns_w << 1);
  end

  logic [LW-1:0] sum_01, sum_11, sum_10;
  assign sum_01 = k1 + ns_w;
  assign sum_11 = k1 + bf_w;
  assign sum_10 = k1 + ns_w + bf_w;

  assign a00_o  = k1[LW-2:0];
  assign a01_o  = sum_01[LW-2:0];
  assign a11_o  = sum_11[LW-2:0];
  assign a10_o  = sum_10[LW-2:0];
  assign bank_o = ^k1;

  logic unused_m;
  assign unused_m = ^m_i[MB-1:0] & 1'b0;
endmodule

// File: rtl/fft_addr_gen.sv
module fft_addr_gen
  import fft_ag_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          step_i,
  output logic [AW-1:0] a00_o,
  output logic [AW-1:0] a10_o,
  output logic [AW-1:0] a01_o,
  output logic [AW-1:0] a11_o,
  output logic          bank_o,
  output logic [SW-1:0] stage_o,
  output logic          valid_o
);
  logic             act;
  logic [LOG_N-1:0] cnt;
  logic [SW-1:0]    stage;

  fft_ag_seq #(.LW(LOG_N), .SB(SW)) i_seq (
    .clk_i, .rst_ni, .mode_i, .step_i,
    .act_o(act), .cnt_o(cnt), .stage_o(stage)
  );

  logic [AW-1:0] io_addr;
  logic          io_bank;

  fft_ag_io #(.LW(LOG_N)) i_io (
    .rev_i(mode_i == MODE_OUT), .idx_i(cnt),
    .addr_o(io_addr), .bank_o(io_bank)
  );

  logic [AW-1:0] b00, b10, b01, b11;
  logic          b_bank;

  fft_ag_bfly #(.LW(LOG_N), .SB(SW)) i_bfly (
    .m_i(cnt[MW-1:0]), .stage_i(stage),
    .a00_o(b00), .a10_o(b10), .a01_o(b01), .a11_o(b11), .bank_o(b_bank)
  );

  logic is_fft;
  assign is_fft = mode_i == MODE_FFT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a00_o   <= '0;
      a10_o   <= '0;
      a01_o   <= '0;
      a11_o   <= '0;
      bank_o  <= 1'b0;
      stage_o <= SW'(1);
      valid_o <= 1'b0;
    end else begin
      valid_o <= act;
      if (act) begin
        a00_o   <= is_fft ? b00 : io_addr;
        a10_o   <= is_fft ? b10 : '0;
        a01_o   <= is_fft ? b01 : '0;
        a11_o   <= is_fft ? b11 : '0;
        bank_o  <= is_fft ? b_bank : io_bank;
        stage_o <= stage;
      end
    end
  end
endmodule

// File: rtl/fft_addr_gen_chk.sv
module fft_addr_gen_chk
  import fft_ag_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    mode_i,
  input logic          step_i,
  input logic [AW-1:0] a00_o,
  input logic [AW-1:0] a10_o,
  input logic [AW-1:0] a01_o,
  input logic [AW-1:0] a11_o,
  input logic          bank_o,
  input logic [SW-1:0] stage_o,
  input logic          valid_o
);
  logic acc;
  logic fft_q, io_q;
  assign acc = step_i && (mode_i != MODE_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fft_q <= 1'b0;
      io_q  <= 1'b0;
    end else begin
      fft_q <= mode_i == MODE_FFT;
      io_q  <= (mode_i == MODE_IN) || (mode_i == MODE_OUT);
    end
  end

  AST_VALID_ON_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> valid_o); // R2
  AST_NO_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !valid_o); // R2
  AST_HOLD_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> $stable(a00_o) && $stable(a10_o) && $stable(a01_o) && $stable(a11_o)
             && $stable(bank_o) && $stable(stage_o)); // R11
  AST_STAGE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_o >= SW'(1)) && (stage_o <= SW'(LOG_N))); // R9
  AST_QUAD_UNION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && fft_q) |-> (a10_o == (a01_o | a11_o)) && (a00_o == (a01_o & a11_o))); // R7
  AST_IO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && io_q) |-> (a10_o == '0) && (a01_o == '0) && (a11_o == '0)); // R10
endmodule

bind fft_addr_gen fft_addr_gen_chk i_chk (.*);

// File: tb/test_fft_addr_gen.sv
module test_fft_addr_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic       step_i = 1'b0;
  logic [8:0] a00_o, a10_o, a01_o, a11_o;
  logic       bank_o, valid_o;
  logic [3:0] stage_o;

  fft_addr_gen i_fft_addr_gen (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  logic [1:0] md_q = 2'd0;
  int cnt_q = 0, stg_q = 1;
  logic [8:0] e00 = 0, e10 = 0, e01 = 0, e11 = 0;
  logic eb = 0, ev = 0;
  logic [3:0] es = 1;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int bitrev10(int v);
    int r = 0;
    for (int b = 0; b < 10; b++) if (v[b]) r |= 1 << (9 - b);
    return r;
  endfunction

  function automatic int par(int v);
    int p = 0;
    for (int b = 0; b < 10; b++) p ^= v[b];
    return p;
  endfunction

  function automatic int widen(int m, int s);
    int p = (s <= 2) ? 8 : 10 - s;
    int lo = m & ((1 << p) - 1);
    return lo | ((m >> p) << (p + 2));
  endfunction

  task automatic drive(logic [1:0] md, logic st);
    int c, s;
    string rq;
    mode_i = md;
    step_i = st;
    c = (md != md_q) ? 0 : cnt_q;
    s = (md != md_q) ? 1 : stg_q;
    ev = st && md != 2'd3;
    if (ev) begin
      if (md == 2'd1) begin
        int k = widen(c & 255, s);
        int ns = 1024 >> s;
        int bf = (s == 1) ? ns / 2 : ns * 2;
        e00 = 9'(k); e01 = 9'(k + ns); e11 = 9'(k + bf); e10 = 9'(k + ns + bf);
        eb = 1'(par(k));
        es = 4'(s);
        if ((c & 255) == 255) s = (s == 10) ? 1 : s + 1;
      end else begin
        int ix = (md == 2'd2) ? bitrev10(c) : c;
        e00 = 9'(ix); e01 = 0; e10 = 0; e11 = 0;
        eb = 1'(par(ix));
        es = 4'(s);
      end
      c = (c + 1) % 1024;
    end
    md_q = md; cnt_q = c; stg_q = s;
    @(posedge clk_i);
    @(negedge clk_i);
    rq = (md == 2'd1) ? "R6_R7" : (md == 2'd2) ? "R4" : "R3";
    if (!ev) rq = "R11";
    chk("R2 valid", int'(valid_o), int'(ev));
    chk({rq, " a00"}, int'(a00_o), int'(e00));
    chk({rq, " a01"}, int'(a01_o), int'(e01));
    chk({rq, " a11"}, int'(a11_o), int'(e11));
    chk({rq, " a10 R10"}, int'(a10_o), int'(e10));
    chk((md == 2'd1) ? "R8 bank" : "R3 bank", int'(bank_o), int'(eb));
    chk("R9 stage", int'(stage_o), int'(es));
  endtask

  initial begin
    #23;
    chk("R1 valid", int'(valid_o), 0);
    chk("R1 stage", int'(stage_o), 1);
    chk("R1 a00", int'(a00_o), 0);
    chk("R1 bank", int'(bank_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R3: load pass with wrap
    for (int i = 0; i < 1030; i++) drive(2'd0, 1'b1);
    // R5: mode change restarts, R4 unload
    for (int i = 0; i < 40; i++) drive(2'd2, 1'b1);
    drive(2'd3, 1'b1);
    drive(2'd3, 1'b0);
    // R6 R7 R9: full ten-stage pass plus wrap to stage 1
    for (int i = 0; i < 2600; i++) drive(2'd1, 1'b1);
    drive(2'd1, 1'b0);
    drive(2'd0, 1'b1);
    void'($urandom(32'h5eed));
    for (int i = 0; i < 6000; i++) begin
      logic [1:0] md = ($urandom_range(0, 39) == 0) ? 2'($urandom_range(0, 3)) : md_q;
      drive(md, 1'($urandom_range(0, 3) != 0));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule